// File: doc/BRIEF.md
# Tolerant Sync Word Detector

This block sits behind a bit-recovery stage and hunts for a programmed synchronisation pattern in the incoming serial stream. Every qualified bit, flagged by a bit-clock enable, is shifted into a 32-bit history. The most recent 8, 16, 24 or 32 bits are compared with the leading bytes of a 32-bit pattern input. The number of differing bits is counted, and a match is declared when that count does not exceed a programmed tolerance of 0 to 3.

A match produces a one-cycle pulse that marks the bit completing the sync word. The detector then disarms until a re-arm strobe arrives, typically from the frame handler when a frame ends or a restart is needed. While disarmed, a byte framer groups the bits that follow the sync word into bytes and pulses a valid strobe on every eighth bit. The first bit after the sync word becomes the most significant bit of the first byte.

Top module: `sync_hunter`

## Requirements
- R1: Bits enter the history in arrival order. A window of L bits matches when its oldest bit is compared with `pattern_i[31]` and its newest bit with `pattern_i[32-L]`, so the first-transmitted byte sits in `pattern_i[31:24]`.
- R2: `size_sel_i` selects the window length L: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. The window always uses the leading (most significant) bytes of `pattern_i`.
- R3: A window matches when the count of positions where it differs from the pattern is less than or equal to `tol_i`, which ranges from 0 to 3.
- R4: On a match, `sync_pulse_o` is high for exactly the one cycle after the clock edge that sampled the final sync bit (`bit_en_i` high). No pulse is produced on any other bit.
- R5: No match is declared until at least L bits have been taken since reset.
- R6: While `hunt_en_i` is low, `sync_pulse_o` stays low whatever the stream.
- R7: After a pulse, the detector ignores further matches until `rearm_i` has been high for at least one clock edge. Re-arming does not clear the bit history.
- R8: The byte count restarts at each detection. On every eighth qualified bit after it, `byte_vld_o` is high for one cycle and `byte_o` holds those eight bits, with the earliest of them in bit 7. `byte_vld_o` stays low while the detector is armed.
- R9: After reset, `sync_pulse_o` and `byte_vld_o` are low, `byte_o` is zero and the detector is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies `bit_i` for one cycle |
| bit_i | input | 1 | Recovered serial data bit |
| hunt_en_i | input | 1 | Enables sync recognition |
| size_sel_i | input | 2 | Window length select (8/16/24/32 bits) |
| tol_i | input | 2 | Maximum tolerated mismatching bits |
| pattern_i | input | 32 | Sync pattern, first-sent bit in bit 31 |
| rearm_i | input | 1 | Re-enables detection after a hit |
| sync_pulse_o | output | 1 | One-cycle sync-found pulse |
| byte_o | output | 8 | Last assembled byte after sync |
| byte_vld_o | output | 1 | One-cycle strobe when `byte_o` is new |

## Verification
Some properties are checked on every cycle. A pulse always follows a qualified bit taken while hunting was enabled. Its mismatch count never exceeds the tolerance. Enough bits had already been received for the selected window. The pulse is never two cycles long, and it never coincides with a byte strobe. Only the bench scenarios can show that the correct window and pattern bytes are compared, and that the pulse lands on the exact completing bit rather than early or late. They also show that a hit at tolerance plus one is rejected, that re-arming is needed, and that bytes are aligned to the detection point. The bench covers these by sweeping every size and tolerance against patterns carrying 0 to 4 injected errors, with a bit-level model running alongside.

// File: rtl/sync_pkg.sv
package sync_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned MAX_BYTES = 4;
  localparam int unsigned TOL_BITS  = 2;
endpackage

// File: rtl/sync_shift.sv
module sync_shift #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_i,
  output logic [W-1:0]     hist_nxt_o,
  output logic [CNT_W-1:0] fill_o
);
  logic [W-1:0]     hist_q;
  logic [CNT_W-1:0] fill_q;

  assign hist_nxt_o = {hist_q[W-2:0], bit_i};
  assign fill_o     = fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (bit_en_i) begin
      hist_q <= hist_nxt_o;
      if (fill_q != CNT_W'(W)) fill_q <= fill_q + CNT_W'(1);
    end
  end

  assert_fill_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CNT_W'(W));
endmodule

// File: rtl/sync_mismatch.sv
module sync_mismatch #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     window_i,
  input  logic [W-1:0]     pattern_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] errs_o
);
  logic [CNT_W-1:0] shamt;
  logic [W-1:0]     pat_al, mask, diff;

  // leading bytes of the pattern align with the newest history bits
  assign shamt  = CNT_W'(W) - len_i;
  assign pat_al = pattern_i >> shamt;
  assign mask   = {W{1'b1}} >> shamt;
  assign diff   = (window_i ^ pat_al) & mask;

  always_comb begin
    errs_o = '0;
    for (int i = 0; i < int'(W); i++) errs_o = errs_o + CNT_W'(diff[i]);
  end
endmodule

// File: rtl/sync_byte_framer.sv
module sync_byte_framer #(
  parameter int unsigned BW = 8,
  localparam int unsigned BC_W = $clog2(BW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          restart_i,
  input  logic          locked_i,
  input  logic [BW-1:0] recent_i,
  output logic [BW-1:0] byte_o,
  output logic          byte_vld_o
);
  logic [BC_W-1:0] cnt_q;
  logic            last_bit;

  assign last_bit = (cnt_q == BC_W'(BW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (bit_en_i) begin
        if (restart_i) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + BC_W'(1);
          if (locked_i && last_bit) begin
            byte_o     <= recent_i;
            byte_vld_o <= 1'b1;
          end
        end
      end
    end
  end

  assert_vld_after_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(bit_en_i) && $past(locked_i));
  assert_vld_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o || $past(bit_en_i));
endmodule

// File: rtl/sync_hunter.sv
module sync_hunter
  import sync_pkg::*;
#(
  parameter int unsigned BYTE_W  = BYTE_BITS,
  parameter int unsigned NBYTES  = MAX_BYTES,
  parameter int unsigned TOL_W   = TOL_BITS,
  localparam int unsigned W      = BYTE_W * NBYTES,
  localparam int unsigned SEL_W  = $clog2(NBYTES),
  localparam int unsigned CNT_W  = $clog2(W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              hunt_en_i,
  input  logic [SEL_W-1:0]  size_sel_i,
  input  logic [TOL_W-1:0]  tol_i,
  input  logic [W-1:0]      pattern_i,
  input  logic              rearm_i,
  output logic              sync_pulse_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o
);
  logic [W-1:0]     hist_nxt;
  logic [CNT_W-1:0] fill, len, errs;
  logic             enough, hit, armed_q;

  assign len = (CNT_W'(size_sel_i) + CNT_W'(1)) * CNT_W'(BYTE_W);

  sync_shift #(.W(W), .CNT_W(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bit_i(bit_i),
    .hist_nxt_o(hist_nxt), .fill_o(fill));

  sync_mismatch #(.W(W), .CNT_W(CNT_W)) u_cmp (
    .window_i(hist_nxt), .pattern_i(pattern_i), .len_i(len), .errs_o(errs));

  // the incoming bit counts toward the fill
  assign enough = (fill + CNT_W'(1)) >= len;
  assign hit    = bit_en_i && hunt_en_i && armed_q && enough &&
                  (errs <= CNT_W'(tol_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q      <= 1'b1;
      sync_pulse_o <= 1'b0;
    end else begin
      sync_pulse_o <= hit;
      if (hit)          armed_q <= 1'b0;
      else if (rearm_i) armed_q <= 1'b1;
    end
  end

  sync_byte_framer #(.BW(BYTE_W)) u_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .restart_i(hit),
    .locked_i(!armed_q), .recent_i(hist_nxt[BYTE_W-1:0]),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o));

  assert_pulse_on_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse_o |-> $past(bit_en_i));
  assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse_o |=> !sync_pulse_o);
  assert_pulse_hunting_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse_o |-> $past(hunt_en_i));
  assert_within_tol_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse_o |-> $past(errs) <= CNT_W'($past(tol_i)));
  assert_filled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse_o |-> $past(fill) + CNT_W'(1) >= $past(len));
  assert_disarmed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse_o |-> !armed_q);
  assert_no_byte_at_sync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse_o |-> !byte_vld_o);
endmodule

// File: tb/sim_sync_hunter.sv
module sim_sync_hunter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bit_en = 1'b0, bit_v = 1'b0, hunt_en = 1'b1, rearm = 1'b0;
  logic [1:0]  size_sel = 2'd0, tol = 2'd0;
  logic [31:0] pattern = 32'h0;
  logic        pulse, bvld;
  logic [7:0]  bout;

  int tests = 0, fails = 0;
  logic [31:0] m_hist = '0;
  int          m_fill = 0, m_cnt = 0;
  bit          m_armed = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_hunter u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_v),
    .hunt_en_i(hunt_en), .size_sel_i(size_sel), .tol_i(tol), .pattern_i(pattern),
    .rearm_i(rearm), .sync_pulse_o(pulse), .byte_o(bout), .byte_vld_o(bvld));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // push one bit, check outputs against the arithmetic model
  task automatic push(input logic b, input string req);
    int      len;
    logic [31:0] pat, mask;
    bit      exp_hit, exp_vld;
    logic [7:0] exp_byte;
    len  = 8 * (int'(size_sel) + 1);
    m_hist = {m_hist[30:0], b};
    if (m_fill < 32) m_fill++;
    pat  = pattern >> (32 - len);
    mask = 32'hFFFF_FFFF >> (32 - len);
    exp_hit = hunt_en && m_armed && (m_fill >= len) &&
              ($countones((m_hist ^ pat) & mask) <= int'(tol));
    exp_vld = 1'b0;
    exp_byte = m_hist[7:0];
    if (exp_hit) m_cnt = 0;
    else begin
      if (!m_armed && m_cnt == 7) exp_vld = 1'b1;
      m_cnt = (m_cnt + 1) % 8;
    end
    if (exp_hit) m_armed = 1'b0;
    @(negedge clk); bit_en = 1'b1; bit_v = b;
    @(negedge clk); bit_en = 1'b0;
    check(pulse == exp_hit, {req, " R4 pulse"}, 32'(pulse), 32'(exp_hit));
    check(bvld == exp_vld, "R8 byte strobe", 32'(bvld), 32'(exp_vld));
    if (exp_vld) check(bout == exp_byte, "R8 byte value", 32'(bout), 32'(exp_byte));
  endtask

  task automatic do_rearm();
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
    m_armed = 1'b1;
  endtask

  task automatic push_pattern(input int errs, input string req);
    int len;
    logic [31:0] p;
    len = 8 * (int'(size_sel) + 1);
    p = pattern;
    for (int e = 0; e < errs; e++) p[31 - ((e * 5 + 2) % len)] ^= 1'b1;
    for (int i = 0; i < len; i++) push(p[31 - i], req);
  endtask

  task automatic push_noise(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push(lfsr[0], "R1");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pulse == 1'b0, "R9 pulse", 32'(pulse), 0);
    check(bvld == 1'b0, "R9 strobe", 32'(bvld), 0);
    check(bout == 8'h00, "R9 byte", 32'(bout), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: zero pattern must not match before eight bits arrive
    size_sel = 2'd0; tol = 2'd0; pattern = 32'h00FF_FFFF;
    for (int i = 0; i < 8; i++) push(1'b0, "R5");
    do_rearm();

    // R1 R2 R3: every size and tolerance against 0..4 injected errors
    pattern = 32'hD391_A5C7;
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        for (int e = 0; e < 5; e++) begin
          size_sel = 2'(s); tol = 2'(t);
          push_noise(6);
          do_rearm();
          push_pattern(e, "R2 R3");
        end
      end
    end

    // R8: bytes aligned to detection
    do_rearm();
    size_sel = 2'd1; tol = 2'd0;
    push_pattern(0, "R8");
    for (int i = 0; i < 8; i++) push(8'hA5 >> (7 - i), "R8");
    for (int i = 0; i < 8; i++) push(8'h3C >> (7 - i), "R8");

    // R7: no second hit without re-arm
    push_pattern(0, "R7");
    do_rearm();
    push_pattern(0, "R7");

    // R6: hunting disabled
    do_rearm();
    hunt_en = 1'b0;
    push_pattern(0, "R6");
    hunt_en = 1'b1;
    push_noise(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule